// File: doc/BRIEF.md
# SPI FIFO Interrupt and DMA Request Logic

This block sits between the serial engine of an SPI controller and its register interface. It holds a transmit FIFO and a receive FIFO and reports their fill levels and a status word. From the levels and a set of thresholds it derives interrupt sources and DMA requests. Software pushes transmit words and pops receive words through a simple register write/read port. The serial engine drains the transmit FIFO and fills the receive FIFO through push/pop handshakes.

Three interrupt sources are sticky error flags and are cleared by bit-coded commands. The other two follow the FIFO levels directly. Threshold registers keep only as many bits as the FIFO depth needs, so software can find the depth by writing a large value and reading it back. Clearing the enable bit empties both FIFOs, and the thresholds can be written only while the block is disabled.

Register addresses (4-bit): 0 control (bit 0 enable), 1 TX data push, 2 RX data pop (on a read strobe), 3 TX level, 4 RX level, 5 status, 6 TX interrupt threshold, 7 RX interrupt threshold, 8 interrupt mask, 9 raw interrupts, 10 masked interrupts, 11 interrupt clear, 12 DMA control, 13 TX DMA threshold, 14 RX DMA threshold.

Top module: `spi_fifo_irq_top`

## Requirements
- R1: Words leave each FIFO in the order they entered. The TX and RX level registers (addresses 3 and 4) report the number of words held, from 0 to DEPTH.
- R2: The status register (address 5) has these bits. Bit 0 is busy, defined as enabled and either the engine is busy or the TX FIFO is not empty. Bit 1 is TX full, bit 2 TX empty, bit 3 RX empty and bit 4 RX full. The value after reset is 0x0C.
- R3: A push to a full TX FIFO is dropped, and the level stays at DEPTH. It sets raw interrupt bit 1 (TX overflow).
- R4: A pop of an empty RX FIFO through address 2 returns zero. It sets raw interrupt bit 2 (RX underflow).
- R5: An engine push into a full RX FIFO is dropped. It sets raw interrupt bit 3 (RX overflow).
- R6: Raw bit 0 (TX empty) is 1 while the TX level is at or below the TX interrupt threshold. Raw bit 4 (RX full) is 1 while the RX level is strictly above the RX interrupt threshold. So a threshold of N-1 fires at N words.
- R7: A write to the clear register (address 11) acts per bit. Bit 0 clears all sticky flags, bit 1 clears RX underflow, bit 2 clears RX overflow and bit 3 clears TX overflow. A sticky flag stays set until it is cleared.
- R8: The masked view (address 10) equals raw AND mask. The irq_o output is the OR of the masked bits.
- R9: Each threshold register reads back the written value modulo DEPTH. A threshold write made while the block is enabled is ignored.
- R10: tx_dma_req_o is active when enabled, when DMA control bit 1 is set, and while the TX level is at or below the TX DMA threshold. rx_dma_req_o is active when enabled, when DMA control bit 0 is set, and while the RX level exceeds the RX DMA threshold.
- R11: While the enable bit is 0, both FIFOs are empty and pushes are dropped. Clearing the enable bit flushes any held words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (pops RX at address 2) |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | DW | Register write data |
| reg_rdata_o | output | DW | Register read data (combinational) |
| eng_tx_pop_i | input | 1 | Engine takes the TX head word |
| eng_tx_valid_o | output | 1 | TX FIFO holds a word |
| eng_tx_data_o | output | DW | TX head word |
| eng_rx_push_i | input | 1 | Engine delivers a received word |
| eng_rx_data_i | input | DW | Received word |
| eng_busy_i | input | 1 | Engine is shifting |
| irq_o | output | 1 | Combined masked interrupt |
| tx_dma_req_o | output | 1 | TX DMA request |
| rx_dma_req_o | output | 1 | RX DMA request |

## Verification
The assertions take the strobes and addresses to be driven to known values from reset on. They expect the engine to pop only while eng_tx_valid_o is high, or to accept that a pop of an empty FIFO has no effect. Because the bench drives every input at the falling edge, each strobe stands for exactly one clock cycle. The bench toggles enable only through the control register and changes thresholds only after disabling, except in the one check that shows a write while enabled is ignored.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  localparam logic [3:0] A_CTRL    = 4'd0;
  localparam logic [3:0] A_TXDATA  = 4'd1;
  localparam logic [3:0] A_RXDATA  = 4'd2;
  localparam logic [3:0] A_TXLVL   = 4'd3;
  localparam logic [3:0] A_RXLVL   = 4'd4;
  localparam logic [3:0] A_STATUS  = 4'd5;
  localparam logic [3:0] A_TXTHR   = 4'd6;
  localparam logic [3:0] A_RXTHR   = 4'd7;
  localparam logic [3:0] A_MASK    = 4'd8;
  localparam logic [3:0] A_RAW     = 4'd9;
  localparam logic [3:0] A_STAT    = 4'd10;
  localparam logic [3:0] A_CLR     = 4'd11;
  localparam logic [3:0] A_DMACTL  = 4'd12;
  localparam logic [3:0] A_TXDTHR  = 4'd13;
  localparam logic [3:0] A_RXDTHR  = 4'd14;

  localparam int NIRQ    = 5;
  localparam int IRQ_TXE = 0;
  localparam int IRQ_TXO = 1;
  localparam int IRQ_RXU = 2;
  localparam int IRQ_RXO = 3;
  localparam int IRQ_RXF = 4;

  localparam int CLR_ALL = 0;
  localparam int CLR_RXU = 1;
  localparam int CLR_RXO = 2;
  localparam int CLR_TXO = 3;

  typedef struct packed {
    logic rx_full;
    logic rx_empty;
    logic tx_empty;
    logic tx_full;
    logic busy;
  } status_t;
endpackage

// File: rtl/spi_fifo_buf.sv
module spi_fifo_buf #(
  parameter int DW = 16,
  parameter int AW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] rdata_o,
  output logic [AW:0]   level_o,
  output logic          full_o,
  output logic          empty_o
);
  localparam int DEPTH = 1 << AW;
  localparam int LW    = AW + 1;

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [LW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == LW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;
  assign rdata_o = mem_q[rd_q];
  assign level_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= wr_q + AW'(1);
      if (do_pop)  rd_q <= rd_q + AW'(1);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + LW'(1);
        2'b01:   cnt_q <= cnt_q - LW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push && !flush_i) mem_q[wr_q] <= wdata_i;
  end

  AST_LEVEL_MAX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LW'(DEPTH)); // R1
  AST_FLUSH_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (level_o == '0)); // R11
  AST_FULL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i && !flush_i) |=> full_o); // R3
endmodule

// File: rtl/spi_fifo_irq.sv
module spi_fifo_irq
  import spi_fifo_pkg::*;
#(
  parameter int AW = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW:0]     tx_lvl_i,
  input  logic [AW:0]     rx_lvl_i,
  input  logic [AW-1:0]   tx_thr_i,
  input  logic [AW-1:0]   rx_thr_i,
  input  logic [NIRQ-1:0] mask_i,
  input  logic [3:0]      clr_i,
  input  logic            txo_evt_i,
  input  logic            rxu_evt_i,
  input  logic            rxo_evt_i,
  output logic [NIRQ-1:0] raw_o,
  output logic [NIRQ-1:0] stat_o,
  output logic            irq_o
);
  logic txo_q, rxu_q, rxo_q;
  logic clr_txo, clr_rxu, clr_rxo;

  assign clr_txo = clr_i[CLR_ALL] | clr_i[CLR_TXO];
  assign clr_rxu = clr_i[CLR_ALL] | clr_i[CLR_RXU];
  assign clr_rxo = clr_i[CLR_ALL] | clr_i[CLR_RXO];

  // a new event in the same cycle as a clear wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      txo_q <= 1'b0;
      rxu_q <= 1'b0;
      rxo_q <= 1'b0;
    end else begin
      txo_q <= txo_evt_i | (txo_q & ~clr_txo);
      rxu_q <= rxu_evt_i | (rxu_q & ~clr_rxu);
      rxo_q <= rxo_evt_i | (rxo_q & ~clr_rxo);
    end
  end

  always_comb begin
    raw_o          = '0;
    raw_o[IRQ_TXE] = (tx_lvl_i <= {1'b0, tx_thr_i});
    raw_o[IRQ_TXO] = txo_q;
    raw_o[IRQ_RXU] = rxu_q;
    raw_o[IRQ_RXO] = rxo_q;
    raw_o[IRQ_RXF] = (rx_lvl_i > {1'b0, rx_thr_i});
  end

  assign stat_o = raw_o & mask_i;
  assign irq_o  = |stat_o;

  AST_TXO_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txo_evt_i |=> raw_o[IRQ_TXO]); // R3
  AST_RXO_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rxo_evt_i |=> raw_o[IRQ_RXO]); // R5
  AST_RXU_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_rxu && !rxu_evt_i) |=> !raw_o[IRQ_RXU]); // R7
  AST_TXO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw_o[IRQ_TXO] && !clr_txo) |=> raw_o[IRQ_TXO]); // R7
  AST_MASK_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_i == '0) |-> !irq_o); // R8
endmodule

// File: rtl/spi_fifo_dma.sv
module spi_fifo_dma #(
  parameter int AW = 3
) (
  input  logic          en_i,
  input  logic          tx_dma_en_i,
  input  logic          rx_dma_en_i,
  input  logic [AW:0]   tx_lvl_i,
  input  logic [AW:0]   rx_lvl_i,
  input  logic [AW-1:0] tx_thr_i,
  input  logic [AW-1:0] rx_thr_i,
  output logic          tx_req_o,
  output logic          rx_req_o
);
  assign tx_req_o = en_i & tx_dma_en_i & (tx_lvl_i <= {1'b0, tx_thr_i});
  assign rx_req_o = en_i & rx_dma_en_i & (rx_lvl_i >  {1'b0, rx_thr_i});
endmodule

// File: rtl/spi_fifo_irq_top.sv
module spi_fifo_irq_top
  import spi_fifo_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic          reg_re_i,
  input  logic [3:0]    reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic          eng_tx_pop_i,
  output logic          eng_tx_valid_o,
  output logic [DW-1:0] eng_tx_data_o,
  input  logic          eng_rx_push_i,
  input  logic [DW-1:0] eng_rx_data_i,
  input  logic          eng_busy_i,
  output logic          irq_o,
  output logic          tx_dma_req_o,
  output logic          rx_dma_req_o
);
  localparam int LW = AW + 1;

  logic            en_q;
  logic [AW-1:0]   tx_thr_q, rx_thr_q, txd_thr_q, rxd_thr_q;
  logic [NIRQ-1:0] mask_q;
  logic [1:0]      dmac_q;

  logic [LW-1:0]   tx_lvl, rx_lvl;
  logic            tx_full, tx_empty, rx_full, rx_empty;
  logic [DW-1:0]   tx_head, rx_head;
  logic            tx_push_req, rx_pop_req, thr_wr_ok;
  logic [3:0]      clr_cmd;
  logic [NIRQ-1:0] raw, stat;
  status_t         status;

  assign tx_push_req = reg_we_i & (reg_addr_i == A_TXDATA);
  assign rx_pop_req  = reg_re_i & (reg_addr_i == A_RXDATA);
  assign thr_wr_ok   = reg_we_i & ~en_q;
  assign clr_cmd     = (reg_we_i && reg_addr_i == A_CLR) ? reg_wdata_i[3:0] : 4'b0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q      <= 1'b0;
      tx_thr_q  <= '0;
      rx_thr_q  <= '0;
      txd_thr_q <= '0;
      rxd_thr_q <= '0;
      mask_q    <= '0;
      dmac_q    <= '0;
    end else begin
      if (reg_we_i && reg_addr_i == A_CTRL)   en_q   <= reg_wdata_i[0];
      if (reg_we_i && reg_addr_i == A_MASK)   mask_q <= reg_wdata_i[NIRQ-1:0];
      if (reg_we_i && reg_addr_i == A_DMACTL) dmac_q <= reg_wdata_i[1:0];
      // thresholds are frozen while enabled; upper bits are not stored
      if (thr_wr_ok && reg_addr_i == A_TXTHR)  tx_thr_q  <= reg_wdata_i[AW-1:0];
      if (thr_wr_ok && reg_addr_i == A_RXTHR)  rx_thr_q  <= reg_wdata_i[AW-1:0];
      if (thr_wr_ok && reg_addr_i == A_TXDTHR) txd_thr_q <= reg_wdata_i[AW-1:0];
      if (thr_wr_ok && reg_addr_i == A_RXDTHR) rxd_thr_q <= reg_wdata_i[AW-1:0];
    end
  end

  spi_fifo_buf #(.DW(DW), .AW(AW)) i_tx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (~en_q),
    .push_i  (en_q & tx_push_req),
    .wdata_i (reg_wdata_i),
    .pop_i   (en_q & eng_tx_pop_i),
    .rdata_o (tx_head),
    .level_o (tx_lvl),
    .full_o  (tx_full),
    .empty_o (tx_empty)
  );

  spi_fifo_buf #(.DW(DW), .AW(AW)) i_rx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (~en_q),
    .push_i  (en_q & eng_rx_push_i),
    .wdata_i (eng_rx_data_i),
    .pop_i   (en_q & rx_pop_req),
    .rdata_o (rx_head),
    .level_o (rx_lvl),
    .full_o  (rx_full),
    .empty_o (rx_empty)
  );

  spi_fifo_irq #(.AW(AW)) i_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tx_lvl_i  (tx_lvl),
    .rx_lvl_i  (rx_lvl),
    .tx_thr_i  (tx_thr_q),
    .rx_thr_i  (rx_thr_q),
    .mask_i    (mask_q),
    .clr_i     (clr_cmd),
    .txo_evt_i (en_q & tx_push_req & tx_full),
    .rxu_evt_i (en_q & rx_pop_req & rx_empty),
    .rxo_evt_i (en_q & eng_rx_push_i & rx_full),
    .raw_o     (raw),
    .stat_o    (stat),
    .irq_o     (irq_o)
  );

  spi_fifo_dma #(.AW(AW)) i_dma (
    .en_i        (en_q),
    .tx_dma_en_i (dmac_q[1]),
    .rx_dma_en_i (dmac_q[0]),
    .tx_lvl_i    (tx_lvl),
    .rx_lvl_i    (rx_lvl),
    .tx_thr_i    (txd_thr_q),
    .rx_thr_i    (rxd_thr_q),
    .tx_req_o    (tx_dma_req_o),
    .rx_req_o    (rx_dma_req_o)
  );

  assign status.busy     = en_q & (eng_busy_i | ~tx_empty);
  assign status.tx_full  = tx_full;
  assign status.tx_empty = tx_empty;
  assign status.rx_empty = rx_empty;
  assign status.rx_full  = rx_full;

  assign eng_tx_valid_o = ~tx_empty;
  assign eng_tx_data_o  = tx_head;

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      A_CTRL:   reg_rdata_o = DW'(en_q);
      A_RXDATA: reg_rdata_o = rx_empty ? '0 : rx_head;
      A_TXLVL:  reg_rdata_o = DW'(tx_lvl);
      A_RXLVL:  reg_rdata_o = DW'(rx_lvl);
      A_STATUS: reg_rdata_o = DW'(status);
      A_TXTHR:  reg_rdata_o = DW'(tx_thr_q);
      A_RXTHR:  reg_rdata_o = DW'(rx_thr_q);
      A_MASK:   reg_rdata_o = DW'(mask_q);
      A_RAW:    reg_rdata_o = DW'(raw);
      A_STAT:   reg_rdata_o = DW'(stat);
      A_DMACTL: reg_rdata_o = DW'(dmac_q);
      A_TXDTHR: reg_rdata_o = DW'(txd_thr_q);
      A_RXDTHR: reg_rdata_o = DW'(rxd_thr_q);
      default:  reg_rdata_o = '0;
    endcase
  end

  AST_THR_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q |=> $stable(rx_thr_q)); // R9
  AST_UFLOW_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_pop_req && rx_empty) |-> (reg_rdata_o == '0)); // R4
  AST_TX_DMA_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_full && txd_thr_q != '1) |-> !tx_dma_req_o); // R10
  AST_RX_DMA_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_empty |-> !rx_dma_req_o); // R10
  AST_OFF_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |=> (!eng_tx_valid_o || en_q)); // R11
endmodule

// File: tb/test_spi_fifo_irq_top.sv
`timescale 1ns/1ps
module test_spi_fifo_irq_top;
  localparam int DW = 16;
  localparam int AW = 3;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_we = 1'b0, reg_re = 1'b0;
  logic [3:0]    reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic          tx_pop = 1'b0, tx_valid;
  logic [DW-1:0] tx_data;
  logic          rx_push = 1'b0;
  logic [DW-1:0] rx_data = '0;
  logic          busy = 1'b0;
  logic          irq, tx_req, rx_req;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  spi_fifo_irq_top #(.DW(DW), .AW(AW)) i_spi_fifo_irq_top (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_re_i(reg_re), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .eng_tx_pop_i(tx_pop), .eng_tx_valid_o(tx_valid), .eng_tx_data_o(tx_data),
    .eng_rx_push_i(rx_push), .eng_rx_data_i(rx_data), .eng_busy_i(busy),
    .irq_o(irq), .tx_dma_req_o(tx_req), .rx_dma_req_o(rx_req)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input int d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = DW'(d);
    @(negedge clk);
    reg_we = 1'b0; reg_addr = '0;
  endtask

  task automatic rd(input logic [3:0] a, output int d);
    @(negedge clk);
    reg_addr = a;
    #1 d = int'(reg_rdata);
  endtask

  task automatic pop_rx(output int d);
    @(negedge clk);
    reg_re = 1'b1; reg_addr = 4'd2;
    #1 d = int'(reg_rdata);
    @(negedge clk);
    reg_re = 1'b0; reg_addr = '0;
  endtask

  task automatic eng_push(input int d);
    @(negedge clk);
    rx_push = 1'b1; rx_data = DW'(d);
    @(negedge clk);
    rx_push = 1'b0;
  endtask

  task automatic eng_pop(output int d);
    @(negedge clk);
    d = int'(tx_data);
    tx_pop = 1'b1;
    @(negedge clk);
    tx_pop = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    rd(4'd5, v); chk("R2 status reset", v, 12);
    rd(4'd3, v); chk("R1 tx level reset", v, 0);
    rd(4'd4, v); chk("R1 rx level reset", v, 0);
    chk("R8 irq reset", int'(irq), 0);

    // threshold width sweep while disabled
    for (int a = 6; a <= 7; a++) begin
      for (int x = 0; x < 2 * DEPTH; x++) begin
        wr(4'(a), x); rd(4'(a), v); chk("R9 thr readback", v, x % DEPTH);
      end
    end
    for (int a = 13; a <= 14; a++) begin
      wr(4'(a), DEPTH + 5); rd(4'(a), v); chk("R9 dma thr readback", v, 5);
    end
    wr(4'd0, 1);
    wr(4'd7, 2); rd(4'd7, v); chk("R9 write while enabled ignored", v, DEPTH - 1);
    wr(4'd0, 0);

    // configure
    wr(4'd6, 2); wr(4'd7, 3); wr(4'd13, 3); wr(4'd14, 1);
    wr(4'd8, 5'h1f); wr(4'd12, 3); wr(4'd0, 1);
    chk("R8 irq from tx empty", int'(irq), 1);

    // TX fill sweep
    for (int k = 1; k <= DEPTH; k++) begin
      wr(4'd1, 16'hA000 + k);
      rd(4'd3, v); chk("R1 tx level", v, k);
      rd(4'd9, v); chk("R6 tx empty irq", (v >> 0) & 1, (k <= 2) ? 1 : 0);
      chk("R10 tx dma req", int'(tx_req), (k <= 3) ? 1 : 0);
      rd(4'd5, v); chk("R2 tx full bit", (v >> 1) & 1, (k == DEPTH) ? 1 : 0);
    end
    wr(4'd1, 16'hDEAD);
    rd(4'd3, v); chk("R3 level after overflow", v, DEPTH);
    rd(4'd9, v); chk("R3 tx overflow bit", (v >> 1) & 1, 1);
    rd(4'd5, v); chk("R2 status busy full", v, 11);
    for (int k = 1; k <= DEPTH; k++) begin
      eng_pop(v); chk("R1 tx order", v, 16'hA000 + k);
    end
    chk("R1 tx drained", int'(tx_valid), 0);
    rd(4'd9, v); chk("R7 raw before clear", v, 3);
    wr(4'd11, 8); rd(4'd9, v); chk("R7 clear tx overflow", v, 1);

    // RX fill sweep
    for (int k = 1; k <= DEPTH; k++) begin
      eng_push(16'hB000 + k);
      rd(4'd4, v); chk("R1 rx level", v, k);
      rd(4'd9, v); chk("R6 rx full irq", (v >> 4) & 1, (k > 3) ? 1 : 0);
      chk("R10 rx dma req", int'(rx_req), (k > 1) ? 1 : 0);
      rd(4'd5, v); chk("R2 rx full bit", (v >> 4) & 1, (k == DEPTH) ? 1 : 0);
    end
    eng_push(16'hBEEF);
    rd(4'd4, v); chk("R5 level after overflow", v, DEPTH);
    rd(4'd9, v); chk("R5 rx overflow bit", (v >> 3) & 1, 1);
    for (int k = 1; k <= DEPTH; k++) begin
      pop_rx(v); chk("R1 rx order", v, 16'hB000 + k);
    end
    rd(4'd9, v); chk("R7 overflow sticky", v, 9);
    pop_rx(v); chk("R4 empty read zero", v, 0);
    rd(4'd9, v); chk("R4 underflow bit", v, 13);

    // mask
    wr(4'd8, 4); rd(4'd10, v); chk("R8 masked view", v, 4);
    chk("R8 irq one source", int'(irq), 1);
    wr(4'd8, 0); rd(4'd10, v); chk("R8 all masked", v, 0);
    chk("R8 irq masked off", int'(irq), 0);

    // clear commands
    wr(4'd11, 2); rd(4'd9, v); chk("R7 clear underflow", v, 9);
    wr(4'd11, 4); rd(4'd9, v); chk("R7 clear rx overflow", v, 1);
    pop_rx(v);
    for (int k = 0; k <= DEPTH; k++) wr(4'd1, k);
    rd(4'd9, v); chk("R7 two flags set", v, 6);
    wr(4'd11, 1); rd(4'd9, v); chk("R7 clear all", v, 0);

    // flush on disable
    eng_push(1); eng_push(2);
    rd(4'd4, v); chk("R11 rx before flush", v, 2);
    wr(4'd0, 0);
    rd(4'd3, v); chk("R11 tx flushed", v, 0);
    rd(4'd4, v); chk("R11 rx flushed", v, 0);
    chk("R11 tx valid low", int'(tx_valid), 0);
    chk("R10 tx dma off when disabled", int'(tx_req), 0);
    wr(4'd1, 7); eng_push(7);
    rd(4'd3, v); chk("R11 tx push dropped", v, 0);
    rd(4'd4, v); chk("R11 rx push dropped", v, 0);
    rd(4'd5, v); chk("R2 status idle", v, 12);

    // RX threshold sweep: threshold t fires at t+1 words
    for (int t = 0; t < DEPTH; t++) begin
      wr(4'd0, 0); wr(4'd7, t); wr(4'd0, 1);
      for (int k = 0; k < t; k++) eng_push(k);
      rd(4'd9, v); chk("R6 rxf below", (v >> 4) & 1, 0);
      eng_push(t);
      rd(4'd9, v); chk("R6 rxf at t+1", (v >> 4) & 1, 1);
    end
    wr(4'd0, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule